// File: doc/BRIEF.md
# Clock Failure Detection Controller

This block supervises a main oscillator from a free-running reference clock. Main-clock rising edges are turned into a toggle in the main domain and carried into the reference domain through a two-flop synchronizer. A counter in the reference domain measures the time since the last edge. The monitor declares the main clock stopped after a set number of silent reference cycles. It declares the clock running again after a set number of edges that arrive without such a gap.

Software sees one byte-wide control and status register. The register holds these fields:

- a detection enable
- the system clock select
- a sticky detection flag
- a live main-clock-stopped status bit
- an action select, which chooses between raising an interrupt and requesting a reset

Every write needs the protect-enable input. The enable bit also obeys a separate clock-modification lock. When the clock fails while the CPU runs directly from the main clock, the block can move the clock select to the on-chip oscillator by itself. An acknowledged oscillation-stop reset clears the flag and the reset request. It keeps the enable, the select and the action bits.

Top module: `clk_fail_ctrl`

## Requirements
- R1: After `rst_n` is released, the block presents these values: `rd_data` = 8'h0A (select = 1, status = 1, all other bits 0), `sel_onchip` = 1, `main_stopped` = 1, `irq_pulse` = 0 and `reset_req` = 0.
- R2: The monitor declares a stop in the cycle in which STOP_LIMIT consecutive reference cycles have passed with no synchronized main-clock edge. From then on, `main_stopped` and `rd_data[3]` read 1. A main-clock rising edge is seen by the counter on the third reference rising edge after it.
- R3: While the monitor is stopped, it declares a restart on the RESTART_EDGES-th synchronized edge that arrives with no gap of STOP_LIMIT cycles in between. `main_stopped` then reads 0. A clock whose edges come STOP_LIMIT or more cycles apart stays stopped.
- R4: The flag (`rd_data[2]`) is set on every stop or restart declared while the enable (`rd_data[0]`) is 1. Writing 0 to bit 2 clears it. Writing 1 to bit 2 leaves it unchanged. A detection in the same cycle as a clear wins.
- R5: When the action bit (`rd_data[7]`) is 1, `irq_pulse` is high for exactly one cycle, in the cycle after a detection takes the flag from 0 to 1. Detections while the flag is already 1 raise no pulse.
- R6: A stop declared while the enable is 1, the action bit is 1 and `cpu_src_pll` is 0 sets the select (`rd_data[1]`, `sel_onchip`) to 1. When `cpu_src_pll` is 1, the select is left unchanged.
- R7: A stop declared while the enable is 1 and the action bit is 0 sets `reset_req`. The request holds until `rst_ack`. `rst_ack` clears both the request and the flag, and keeps the enable, select and action bits.
- R8: A write with `prot_en` = 0 changes no register bit.
- R9: While `clk_lock` = 1, a protected write leaves the enable bit unchanged and still updates the other writable bits.
- R10: A protected write of 0 to the select is ignored while the enable is 1 and the main clock is stopped. A write of 1 is accepted.
- R11: Bits 6:4 of `rd_data` always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all register logic runs on it |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted in step with `ref_clk` |
| main_clk | input | 1 | Main oscillator under supervision |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| prot_en | input | 1 | Write protect enable; writes count only when 1 |
| clk_lock | input | 1 | Clock-modification lock; blocks writes to the enable bit |
| cpu_src_pll | input | 1 | 1 when the CPU clock comes from the PLL rather than the main clock |
| rst_ack | input | 1 | Acknowledge of the oscillation-stop reset |
| rd_data | output | 8 | Register read value |
| sel_onchip | output | 1 | System clock select: 1 = on-chip oscillator |
| main_stopped | output | 1 | Live main-clock-stopped status |
| irq_pulse | output | 1 | One-cycle detection interrupt |
| reset_req | output | 1 | Held oscillation-stop reset request |

## Verification
The bench generates a main clock that stops and restarts. It also runs the main clock with periods just below and just above STOP_LIMIT. This way an off-by-one stop count or a restart count that ignores gaps would show up as a wrong status in a specific cycle.

It produces detections while the flag is already set. A design that interrupts on every detection instead of on the flag's rise would emit extra pulses here. It also tries writing 1 to the flag, which must not clear it.

The failover check is repeated with the PLL as source, where a design that ignores the source would wrongly switch the select. The bench also makes protected, unprotected and locked writes, and writes of 0 to the select while the clock is stopped.

// File: rtl/clkf_pkg.sv
package clkf_pkg;
  // Field positions of the control/status byte (software-visible layout)
  localparam int unsigned FLD_EN   = 0;
  localparam int unsigned FLD_SEL  = 1;
  localparam int unsigned FLD_FLAG = 2;
  localparam int unsigned FLD_STAT = 3;
  localparam int unsigned FLD_ACT  = 7;
  localparam int unsigned REG_W    = 8;

  // Reset values of the writable fields
  localparam logic RST_EN  = 1'b0;
  localparam logic RST_SEL = 1'b1;
  localparam logic RST_ACT = 1'b0;

  typedef enum logic {
    MON_RUN  = 1'b0,
    MON_STOP = 1'b1
  } mon_state_e;

  typedef struct packed {
    logic act;
    logic flag;
    logic sel;
    logic en;
  } ctrl_bits_t;
endpackage

// File: rtl/clkf_edge_sync.sv
module clkf_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic main_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic edge_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic                   tog_q;
  logic                   tog_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   hist_q;

  // main-domain toggle: one flip per main-clock rising edge
  always_comb tog_d = ~tog_q;

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  // synchronizer chain into the reference domain
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = tog_q;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], tog_q};
    end
  endgenerate

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= sync_q[LAST];
    end
  end

  always_comb edge_o = sync_q[LAST] ^ hist_q;
endmodule

// File: rtl/clkf_gap_detect.sv
module clkf_gap_detect
  import clkf_pkg::*;
#(
  parameter int unsigned STOP_LIMIT    = 8,
  parameter int unsigned RESTART_EDGES = 4
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic stopped_o,
  output logic stop_evt_o,
  output logic restart_evt_o
);
  localparam int unsigned CW = $clog2(STOP_LIMIT + 1);
  localparam int unsigned RW = $clog2(RESTART_EDGES + 1);
  localparam logic [CW-1:0] LIM      = CW'(STOP_LIMIT);
  localparam logic [RW-1:0] RUN_LAST = RW'(RESTART_EDGES - 1);

  mon_state_e    state_q, state_d;
  logic [CW-1:0] gap_q, gap_d, gap_inc;
  logic [RW-1:0] runs_q, runs_d;
  logic          gap_hit;
  logic          stop_evt, restart_evt;

  always_comb begin
    gap_inc     = (gap_q == LIM) ? gap_q : gap_q + 1'b1;
    gap_d       = edge_i ? '0 : gap_inc;
    gap_hit     = !edge_i && (gap_inc == LIM);
    stop_evt    = (state_q == MON_RUN) && gap_hit && (gap_q != LIM);
    restart_evt = (state_q == MON_STOP) && edge_i && (runs_q == RUN_LAST);

    state_d = state_q;
    if (stop_evt)         state_d = MON_STOP;
    else if (restart_evt) state_d = MON_RUN;

    runs_d = runs_q;
    if (state_q == MON_RUN) runs_d = '0;
    else if (edge_i)        runs_d = restart_evt ? '0 : runs_q + 1'b1;
    else if (gap_hit)       runs_d = '0;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MON_STOP;
      gap_q   <= '0;
      runs_q  <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      runs_q  <= runs_d;
    end
  end

  always_comb begin
    stopped_o     = (state_q == MON_STOP);
    stop_evt_o    = stop_evt;
    restart_evt_o = restart_evt;
  end
endmodule

// File: rtl/clkf_ctrl_reg.sv
module clkf_ctrl_reg
  import clkf_pkg::*;
(
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             prot_en,
  input  logic             clk_lock,
  input  logic             cpu_src_pll,
  input  logic             rst_ack,
  input  logic             stopped_i,
  input  logic             stop_evt_i,
  input  logic             restart_evt_i,
  output logic [REG_W-1:0] rd_data,
  output logic             sel_o,
  output logic             irq_o,
  output logic             rreq_o
);
  ctrl_bits_t cur_q, cur_d;
  logic       irq_q, irq_d;
  logic       rreq_q, rreq_d;
  logic       wr_ok, det_evt, failover, sel_wr_blocked;

  always_comb begin
    wr_ok          = wr_en && prot_en;
    det_evt        = (stop_evt_i || restart_evt_i) && cur_q.en;
    failover       = stop_evt_i && cur_q.en && cur_q.act && !cpu_src_pll;
    sel_wr_blocked = !wr_data[FLD_SEL] && cur_q.en && stopped_i;

    cur_d = cur_q;
    // enable: protected and not locked
    if (wr_ok && !clk_lock) cur_d.en = wr_data[FLD_EN];
    // action select: protected only
    if (wr_ok) cur_d.act = wr_data[FLD_ACT];
    // clock select: failover beats software
    if (failover)                         cur_d.sel = 1'b1;
    else if (wr_ok && !sel_wr_blocked)    cur_d.sel = wr_data[FLD_SEL];
    // sticky flag: detection > reset acknowledge > software clear
    if (det_evt)                          cur_d.flag = 1'b1;
    else if (rst_ack)                     cur_d.flag = 1'b0;
    else if (wr_ok && !wr_data[FLD_FLAG]) cur_d.flag = 1'b0;

    irq_d = det_evt && !cur_q.flag && cur_q.act;

    rreq_d = rreq_q;
    if (stop_evt_i && cur_q.en && !cur_q.act) rreq_d = 1'b1;
    else if (rst_ack)                         rreq_d = 1'b0;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.en   <= RST_EN;
      cur_q.sel  <= RST_SEL;
      cur_q.act  <= RST_ACT;
      cur_q.flag <= 1'b0;
      irq_q      <= 1'b0;
      rreq_q     <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[FLD_EN]   = cur_q.en;
    rd_data[FLD_SEL]  = cur_q.sel;
    rd_data[FLD_FLAG] = cur_q.flag;
    rd_data[FLD_STAT] = stopped_i;
    rd_data[FLD_ACT]  = cur_q.act;
    sel_o             = cur_q.sel;
    irq_o             = irq_q;
    rreq_o            = rreq_q;
  end
endmodule

// File: rtl/clk_fail_ctrl.sv
module clk_fail_ctrl
  import clkf_pkg::*;
#(
  parameter int unsigned STOP_LIMIT    = 8,
  parameter int unsigned RESTART_EDGES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       main_clk,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       prot_en,
  input  logic       clk_lock,
  input  logic       cpu_src_pll,
  input  logic       rst_ack,
  output logic [7:0] rd_data,
  output logic       sel_onchip,
  output logic       main_stopped,
  output logic       irq_pulse,
  output logic       reset_req
);
  logic edge_s;
  logic stopped_s, stop_evt_s, restart_evt_s;

  clkf_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .main_clk (main_clk),
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .edge_o   (edge_s)
  );

  clkf_gap_detect #(
    .STOP_LIMIT    (STOP_LIMIT),
    .RESTART_EDGES (RESTART_EDGES)
  ) u_mon (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .edge_i        (edge_s),
    .stopped_o     (stopped_s),
    .stop_evt_o    (stop_evt_s),
    .restart_evt_o (restart_evt_s)
  );

  clkf_ctrl_reg u_reg (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .prot_en       (prot_en),
    .clk_lock      (clk_lock),
    .cpu_src_pll   (cpu_src_pll),
    .rst_ack       (rst_ack),
    .stopped_i     (stopped_s),
    .stop_evt_i    (stop_evt_s),
    .restart_evt_i (restart_evt_s),
    .rd_data       (rd_data),
    .sel_o         (sel_onchip),
    .irq_o         (irq_pulse),
    .rreq_o        (reset_req)
  );

  always_comb main_stopped = stopped_s;
endmodule

// File: rtl/clkf_ctrl_chk.sv
module clkf_ctrl_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       prot_en,
  input logic       clk_lock,
  input logic       rst_ack,
  input logic [7:0] rd_data,
  input logic       main_stopped,
  input logic       irq_pulse,
  input logic       reset_req
);
  AST_IRQ_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R5
  AST_IRQ_AFTER_RISE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq_pulse |-> (rd_data[2] && !$past(rd_data[2]))); // R5
  AST_RREQ_HELD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (reset_req && !rst_ack) |=> reset_req); // R7
  AST_ACT_NO_UNPROT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(wr_en && prot_en) |=> $stable(rd_data[7])); // R8
  AST_EN_LOCKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (clk_lock || !(wr_en && prot_en)) |=> $stable(rd_data[0])); // R9
  AST_SEL_KEPT_STOPPED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (rd_data[0] && main_stopped && rd_data[1]) |=> rd_data[1]); // R10
endmodule

bind clk_fail_ctrl clkf_ctrl_chk u_chk (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .prot_en      (prot_en),
  .clk_lock     (clk_lock),
  .rst_ack      (rst_ack),
  .rd_data      (rd_data),
  .main_stopped (main_stopped),
  .irq_pulse    (irq_pulse),
  .reset_req    (reset_req)
);

// File: tb/tb_clk_fail_ctrl.sv
`timescale 1ns/1ps
module tb_clk_fail_ctrl;
  localparam int LIM = 8;
  localparam int REQ = 4;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       prot_en = 1'b0;
  logic       clk_lock = 1'b0;
  logic       cpu_src_pll = 1'b0;
  logic       rst_ack = 1'b0;
  logic [7:0] rd_data;
  logic       sel_onchip, main_stopped, irq_pulse, reset_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int irq_cnt = 0;

  clk_fail_ctrl dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .main_clk(main_clk), .wr_en(wr_en),
    .wr_data(wr_data), .prot_en(prot_en), .clk_lock(clk_lock),
    .cpu_src_pll(cpu_src_pll), .rst_ack(rst_ack), .rd_data(rd_data),
    .sel_onchip(sel_onchip), .main_stopped(main_stopped),
    .irq_pulse(irq_pulse), .reset_req(reset_req)
  );

  always #4 ref_clk = ~ref_clk; // 125 MHz

  // main clock generator, edges aligned to reference falling edges
  bit main_run = 1'b0;
  int half = 1;
  int ph = 0;
  bit tb_tog = 1'b0;
  always @(negedge ref_clk) begin
    if (main_run) begin
      if (ph >= half - 1) begin
        ph = 0;
        if (!main_clk) tb_tog = ~tb_tog;
        main_clk <= ~main_clk;
      end else ph = ph + 1;
    end
  end

  // behavioural reference model
  bit q_s1, q_s2, q_s3;
  int m_gap, m_runs;
  bit m_stop, m_en, m_sel, m_flag, m_act, m_irq, m_rreq;
  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      q_s1 = 0; q_s2 = 0; q_s3 = 0;
      m_gap = 0; m_runs = 0; m_stop = 1; m_en = 0; m_sel = 1;
      m_flag = 0; m_act = 0; m_irq = 0; m_rreq = 0;
    end else begin
      bit e, gap, sev, rev, wr, ev;
      int ng;
      e   = q_s2 ^ q_s3;
      ng  = e ? 0 : ((m_gap < LIM) ? m_gap + 1 : m_gap);
      gap = !e && ng == LIM;
      sev = !m_stop && gap && m_gap != LIM;
      rev = m_stop && e && (m_runs + 1 == REQ);
      wr  = wr_en && prot_en;
      ev  = (sev || rev) && m_en;
      m_irq = ev && !m_flag && m_act;
      if (sev && m_en && !m_act) m_rreq = 1;
      else if (rst_ack) m_rreq = 0;
      if (sev && m_en && m_act && !cpu_src_pll) m_sel = 1;
      else if (wr && !(!wr_data[1] && m_en && m_stop)) m_sel = wr_data[1];
      if (ev) m_flag = 1;
      else if (rst_ack) m_flag = 0;
      else if (wr && !wr_data[2]) m_flag = 0;
      if (wr && !clk_lock) m_en = wr_data[0];
      if (wr) m_act = wr_data[7];
      if (!m_stop) m_runs = 0;
      else if (e) m_runs = rev ? 0 : m_runs + 1;
      else if (gap) m_runs = 0;
      if (sev) m_stop = 1;
      else if (rev) m_stop = 0;
      m_gap = ng;
      q_s3 = q_s2; q_s2 = q_s1; q_s1 = tb_tog;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge ref_clk) begin
    cyc++;
    if (rst_n) begin
      if (irq_pulse) irq_cnt++;
      chk("R2 status", {31'd0, main_stopped}, {31'd0, m_stop});
      chk("R3 status bit", {31'd0, rd_data[3]}, {31'd0, m_stop});
      chk("R4 flag", {31'd0, rd_data[2]}, {31'd0, m_flag});
      chk("R5 irq", {31'd0, irq_pulse}, {31'd0, m_irq});
      chk("R6 select", {31'd0, sel_onchip}, {31'd0, m_sel});
      chk("R7 reset request", {31'd0, reset_req}, {31'd0, m_rreq});
      chk("R8 enable/action", {30'd0, rd_data[7], rd_data[0]}, {30'd0, m_act, m_en});
      chk("R11 reserved", {29'd0, rd_data[6:4]}, 0);
    end
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic prot);
    @(negedge ref_clk);
    wr_en = 1'b1; wr_data = d; prot_en = prot;
    @(negedge ref_clk);
    wr_en = 1'b0; prot_en = 1'b0;
  endtask

  initial begin
    int irq0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 rd_data", rd_data, 8'h0A);
    chk("R1 outputs", {sel_onchip, main_stopped, irq_pulse, reset_req}, 4'b1100);

    // main clock runs: restart with detection disabled, no flag
    main_run = 1; step(20);
    chk("R3 running", main_stopped, 0);
    chk("R4 no flag while disabled", rd_data[2], 0);

    wr(8'h81, 1'b1);                 // enable, interrupt action, select main
    wr(8'h00, 1'b0);                 // unprotected: ignored
    chk("R8 unprotected write", rd_data, 8'h81);

    // stop: flag, interrupt, failover
    irq0 = irq_cnt;
    main_run = 0; step(20);
    chk("R2 stop", main_stopped, 1);
    chk("R4 flag on stop", rd_data[2], 1);
    chk("R5 one pulse on stop", irq_cnt - irq0, 1);
    chk("R6 failover", sel_onchip, 1);

    // restart while flag set: silent
    irq0 = irq_cnt;
    main_run = 1; step(20);
    chk("R3 restart", main_stopped, 0);
    chk("R5 silent while flag set", irq_cnt - irq0, 0);
    wr(8'h87, 1'b1);
    chk("R4 write 1 keeps flag", rd_data[2], 1);
    wr(8'h81, 1'b1);
    chk("R4 write 0 clears flag", rd_data[2], 0);

    // PLL source: no failover
    cpu_src_pll = 1; irq0 = irq_cnt;
    main_run = 0; step(20);
    chk("R6 no failover from PLL", sel_onchip, 0);
    chk("R5 pulse on second stop", irq_cnt - irq0, 1);
    wr(8'h83, 1'b1);
    wr(8'h81, 1'b1);
    chk("R10 select 0 ignored while stopped", sel_onchip, 1);

    clk_lock = 1;
    wr(8'h02, 1'b1);
    chk("R9 enable kept under lock", rd_data[0], 1);
    chk("R9 action still written", rd_data[7], 0);
    clk_lock = 0; cpu_src_pll = 0;

    // reset-request action
    main_run = 1; step(20);
    wr(8'h71, 1'b1);                 // enable, action reset, select main
    chk("R11 reserved read 0", rd_data, 8'h01);
    main_run = 0; step(20);
    chk("R7 request set", reset_req, 1);
    step(10);
    chk("R7 request held", reset_req, 1);
    @(negedge ref_clk); rst_ack = 1;
    @(negedge ref_clk); rst_ack = 0;
    chk("R7 request cleared", reset_req, 0);
    chk("R7 bits kept, flag cleared", rd_data, 8'h09);

    // too slow a main clock stays stopped; just fast enough restarts
    half = 5; main_run = 1; step(80);
    chk("R3 gap too long stays stopped", main_stopped, 1);
    half = 3; step(40);
    chk("R3 period below limit restarts", main_stopped, 0);
    main_run = 0; step(20);
    chk("R2 final stop", main_stopped, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule